// File: doc/BRIEF.md
# Slave Port Request Arbiter

This block sits in front of a single slave port of a crossbar interconnect. Each of up to sixteen masters raises a request line, and the arbiter names one owner of the port through a one-hot grant vector and a valid flag. A one-bit static input picks the policy. In rotating mode the search starts just past the previously granted master. In priority mode the largest 4-bit priority value wins.

A grant is kept while the owner keeps requesting, and it is only reconsidered at the edge where a transfer beat completes (`ready` high). Two limits can end an owner's tenure at such an edge:
- a per-master cap on the number of beats in a burst of unstated length;
- a per-port cap on the number of cycles the port is held.

When nobody requests, a two-bit parking mode decides what the grant shows: nothing, the most recent owner, or a configured master.

All configuration arrives as static vectors. The grant is registered: it reflects requests sampled at the previous clock edge.

Top module: `bus_slot_arbiter`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `gnt` is all zeros and `gnt_valid` is 0.
- R2: `gnt` has at most one bit set, and `gnt_valid` is 1 exactly when one bit is set.
- R3: With `arb_fixed`=0, a new grant goes to the first requesting master found by scanning upward from the index after the last granted master, wrapping past the top index. After reset the scan starts at master 0.
- R4: With `arb_fixed`=1, a new grant goes to the requester whose 4-bit field `prio_vec[4i+3:4i]` is numerically largest. Among equal values, the lower index wins.
- R5: While the owner requests and `ready` is 0, `gnt` does not change at the next edge.
- R6: When the owner stops requesting, the grant is decided again at that edge from the other requests and the parking mode. The result is visible on the following cycle.
- R7: The 3-bit field `blim_vec[3i+2:3i]` caps master i's burst. The codes are 1 for one beat, 2 for four beats, 3 for eight beats and 4 for sixteen beats; 0 and 5 to 7 mean no cap. At the `ready` edge that completes the capped beat count, the grant is decided again, with the owner still a candidate.
- R8: When `slot_cycles`=S is non-zero, an owner that has held the port for S or more cycles (counting the current one) is re-arbitrated at its next `ready` edge. S=0 disables this limit.
- R9: With `park_mode` 0 or 3 and no requests, the grant goes to all zeros with `gnt_valid` 0 on the next cycle.
- R10: With `park_mode`=1 and no requests, the grant stays on the most recently granted master. If no master has been granted since reset, nothing is granted.
- R11: With `park_mode`=2 and no requests, master `park_id` is granted with `gnt_valid` 1 on the next cycle.
- R12: A grant decided at a clock edge appears on `gnt` right after that edge, one cycle after the requests that caused it were presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NUM_MASTERS | Request line for each master |
| ready | input | 1 | Current beat completes this cycle |
| arb_fixed | input | 1 | 0 = rotating, 1 = priority arbitration |
| park_mode | input | 2 | 0 none, 1 last owner, 2 fixed master, 3 none |
| park_id | input | MID_W | Master to park on in mode 2 |
| prio_vec | input | NUM_MASTERS*4 | Priority value for each master |
| blim_vec | input | NUM_MASTERS*3 | Burst cap code for each master |
| slot_cycles | input | SLOT_W | Port hold limit in cycles, 0 = off |
| gnt | output | NUM_MASTERS | One-hot grant |
| gnt_valid | output | 1 | A master is granted |

## Verification
The burst-beat cap and the hold-cycle limit can expire on the same `ready` edge. They can also expire on different edges, where one limit is already pending while the other counter is still running. A phase runs every master with a four-beat cap, `slot_cycles` set to four and `ready` always high, so both limits hit together. Other phases draw random caps, random slot limits and random `ready`, so the two limits also land apart. Each cycle is judged against a behavioural model that recounts beats and held cycles with plain integers. A master whose burst runs out while it is also parked or still requesting must come back only through the arbitration rule in force.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int PRIO_W = 4;
    localparam int BLIM_W = 3;
    localparam int BEAT_W = 5;

    typedef enum logic [1:0] {
        PARK_NONE  = 2'd0,
        PARK_LAST  = 2'd1,
        PARK_FIXED = 2'd2
    } park_mode_e;

    typedef struct packed {
        logic burst_out;
        logic slot_out;
    } hold_stat_t;

    function automatic logic [BEAT_W-1:0] blim_beats(input logic [BLIM_W-1:0] code);
        case (code)
            3'd1:    return BEAT_W'(1);
            3'd2:    return BEAT_W'(4);
            3'd3:    return BEAT_W'(8);
            3'd4:    return BEAT_W'(16);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int NUM_MASTERS = 16,
    parameter int MID_W       = 4
) (
    input  logic [NUM_MASTERS-1:0] req,
    input  logic [MID_W-1:0]       last,
    output logic [MID_W-1:0]       pick
);
    int idx;

    always_comb begin
        pick = '0;
        idx  = 0;
        // scan downward in distance so the nearest requester is written last
        for (int k = NUM_MASTERS; k >= 1; k--) begin
            idx = int'(last) + k;
            if (idx >= NUM_MASTERS) idx = idx - NUM_MASTERS;
            if (req[idx]) pick = MID_W'(idx);
        end
    end
endmodule

// File: rtl/arb_prio_pick.sv
module arb_prio_pick
    import arb_pkg::*;
#(
    parameter int NUM_MASTERS = 16,
    parameter int MID_W       = 4
) (
    input  logic [NUM_MASTERS-1:0]        req,
    input  logic [NUM_MASTERS*PRIO_W-1:0] prio_vec,
    output logic [MID_W-1:0]              pick
);
    logic [PRIO_W-1:0] best;
    logic              seen;

    always_comb begin
        pick = '0;
        best = '0;
        seen = 1'b0;
        // strict compare keeps the lower index on equal values
        for (int i = 0; i < NUM_MASTERS; i++) begin
            if (req[i] && (!seen || prio_vec[i*PRIO_W +: PRIO_W] > best)) begin
                pick = MID_W'(i);
                best = prio_vec[i*PRIO_W +: PRIO_W];
                seen = 1'b1;
            end
        end
    end
endmodule

// File: rtl/arb_hold_ctrl.sv
module arb_hold_ctrl
    import arb_pkg::*;
#(
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              active,
    input  logic              ready,
    input  logic [BLIM_W-1:0] lim_code,
    input  logic [SLOT_W-1:0] slot_cycles,
    output hold_stat_t        stat
);
    logic [BEAT_W-1:0] beat_cnt_q;
    logic [SLOT_W-1:0] slot_cnt_q;
    logic [BEAT_W-1:0] lim;

    assign lim = blim_beats(lim_code);

    always_comb begin
        stat.burst_out = (lim != '0) && (beat_cnt_q == lim - BEAT_W'(1));
        stat.slot_out  = (slot_cycles != '0) &&
                         (({1'b0, slot_cnt_q} + (SLOT_W+1)'(1)) >= {1'b0, slot_cycles});
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            beat_cnt_q <= '0;
            slot_cnt_q <= '0;
        end else begin
            if (active && ready) beat_cnt_q <= beat_cnt_q + BEAT_W'(1);
            if (slot_cnt_q != '1) slot_cnt_q <= slot_cnt_q + SLOT_W'(1);
        end
    end

    AST_BEAT_RESTART: assert property (@(posedge clk) disable iff (rst)
        restart |=> (beat_cnt_q == '0) && (slot_cnt_q == '0)); // R7
endmodule

// File: rtl/bus_slot_arbiter.sv
module bus_slot_arbiter
    import arb_pkg::*;
#(
    parameter  int NUM_MASTERS = 16,
    parameter  int SLOT_W      = 8,
    localparam int MID_W       = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_MASTERS-1:0]        req,
    input  logic                          ready,
    input  logic                          arb_fixed,
    input  logic [1:0]                    park_mode,
    input  logic [MID_W-1:0]              park_id,
    input  logic [NUM_MASTERS*PRIO_W-1:0] prio_vec,
    input  logic [NUM_MASTERS*BLIM_W-1:0] blim_vec,
    input  logic [SLOT_W-1:0]             slot_cycles,
    output logic [NUM_MASTERS-1:0]        gnt,
    output logic                          gnt_valid
);
    logic [MID_W-1:0] owner_q, last_q, rr_pick, pr_pick, win;
    logic             valid_q, has_last_q;
    logic             owner_req, arb_pt;
    hold_stat_t       hstat;

    arb_rr_pick #(.NUM_MASTERS(NUM_MASTERS), .MID_W(MID_W)) u_rr (
        .req(req), .last(last_q), .pick(rr_pick));

    arb_prio_pick #(.NUM_MASTERS(NUM_MASTERS), .MID_W(MID_W)) u_pr (
        .req(req), .prio_vec(prio_vec), .pick(pr_pick));

    assign owner_req = valid_q && req[owner_q];
    assign win       = arb_fixed ? pr_pick : rr_pick;
    // decisions only at a beat edge, or whenever no beat is in flight
    assign arb_pt    = !owner_req || (ready && (hstat.burst_out || hstat.slot_out));

    arb_hold_ctrl #(.SLOT_W(SLOT_W)) u_hold (
        .clk(clk), .rst(rst), .restart(arb_pt), .active(owner_req), .ready(ready),
        .lim_code(blim_vec[owner_q*BLIM_W +: BLIM_W]),
        .slot_cycles(slot_cycles), .stat(hstat));

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_q    <= '0;
            valid_q    <= 1'b0;
            last_q     <= MID_W'(NUM_MASTERS - 1);
            has_last_q <= 1'b0;
        end else if (arb_pt) begin
            if (|req) begin
                owner_q    <= win;
                valid_q    <= 1'b1;
                last_q     <= win;
                has_last_q <= 1'b1;
            end else begin
                case (park_mode)
                    PARK_LAST: begin
                        owner_q <= last_q;
                        valid_q <= has_last_q;
                    end
                    PARK_FIXED: begin
                        owner_q <= park_id;
                        valid_q <= (int'(park_id) < NUM_MASTERS);
                    end
                    default: valid_q <= 1'b0;
                endcase
            end
        end
    end

    for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_gnt
        assign gnt[g] = valid_q && (owner_q == MID_W'(g));
    end
    assign gnt_valid = valid_q;

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt) && (gnt_valid == (gnt != '0))); // R2
    AST_MID_BEAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid && |(gnt & req) && !ready) |=> $stable(gnt)); // R5
    AST_PARK_NONE: assert property (@(posedge clk) disable iff (rst)
        (req == '0 && (park_mode == 2'd0 || park_mode == 2'd3)) |=> !gnt_valid); // R9
    AST_PARK_FIXED: assert property (@(posedge clk) disable iff (rst)
        (req == '0 && park_mode == 2'd2 && int'(park_id) < NUM_MASTERS)
        |=> gnt_valid && gnt[$past(park_id)]); // R11
endmodule

// File: tb/sim_bus_slot_arbiter.sv
module sim_bus_slot_arbiter;
    localparam int N  = 16;
    localparam int SW = 8;
    localparam int MW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  req = '0;
    logic          ready = 1'b0;
    logic          arb_fixed = 1'b0;
    logic [1:0]    park_mode = 2'd0;
    logic [MW-1:0] park_id = '0;
    logic [N*4-1:0] prio_vec = '0;
    logic [N*3-1:0] blim_vec = '0;
    logic [SW-1:0] slot_cycles = '0;
    logic [N-1:0]  gnt;
    logic          gnt_valid;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    bus_slot_arbiter #(.NUM_MASTERS(N), .SLOT_W(SW)) u0 (
        .clk(clk), .rst(rst), .req(req), .ready(ready), .arb_fixed(arb_fixed),
        .park_mode(park_mode), .park_id(park_id), .prio_vec(prio_vec),
        .blim_vec(blim_vec), .slot_cycles(slot_cycles), .gnt(gnt), .gnt_valid(gnt_valid));

    always #2 clk = ~clk;

    // behavioural reference state
    int m_owner = 0, m_valid = 0, m_last = N - 1, m_has_last = 0;
    int m_beats = 0, m_held = 0;

    function automatic int beats_of(input int code);
        if (code == 1) return 1;
        if (code == 2) return 4;
        if (code == 3) return 8;
        if (code == 4) return 16;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_owner = 0; m_valid = 0; m_last = N - 1; m_has_last = 0;
            m_beats = 0; m_held = 0;
        end else begin
            int lim;
            bit busy, end_burst, end_slot;
            busy      = (m_valid != 0) && req[m_owner];
            lim       = beats_of(int'(blim_vec[m_owner*3 +: 3]));
            end_burst = (lim > 0) && (m_beats == lim - 1);
            end_slot  = (slot_cycles != 0) && (m_held + 1 >= int'(slot_cycles));
            if (!busy || (ready && (end_burst || end_slot))) begin
                int pick;
                pick = -1;
                if (arb_fixed) begin
                    for (int i = 0; i < N; i++)
                        if (req[i] && (pick < 0 || prio_vec[i*4 +: 4] > prio_vec[pick*4 +: 4]))
                            pick = i;
                end else begin
                    for (int k = 1; k <= N; k++)
                        if (pick < 0 && req[(m_last + k) % N]) pick = (m_last + k) % N;
                end
                if (pick >= 0) begin
                    m_owner = pick; m_valid = 1; m_last = pick; m_has_last = 1;
                end else if (park_mode == 2'd1) begin
                    m_owner = m_last; m_valid = m_has_last;
                end else if (park_mode == 2'd2) begin
                    m_owner = int'(park_id); m_valid = 1;
                end else begin
                    m_valid = 0;
                end
                m_beats = 0; m_held = 0;
            end else begin
                if (ready) m_beats = (m_beats + 1) % 32;
                if (m_held < 255) m_held = m_held + 1;
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        logic [N-1:0] exp_g;
        exp_g = (m_valid != 0) ? (N'(1) << m_owner) : '0;
        checks++;
        if (gnt !== exp_g || gnt_valid !== (m_valid != 0)) begin
            errors++;
            $display("FAIL %s: gnt=%h valid=%b expected gnt=%h valid=%0d",
                     tag, gnt, gnt_valid, exp_g, m_valid);
        end
        checks++;
        if ($countones(gnt) > 1 || gnt_valid !== (gnt != '0)) begin
            errors++;
            $display("FAIL R2: gnt=%h valid=%b expected one-hot matching valid", gnt, gnt_valid);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_gnt(input logic [N-1:0] e, input string t);
        checks++;
        if (gnt !== e) begin
            errors++;
            $display("FAIL %s: gnt=%h expected %h", t, gnt, e);
        end
    endtask

    task automatic rand_run(input int n, input int req_pct, input int rdy_pct);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            if (($urandom % 100) < req_pct) req = N'($urandom);
            else if (($urandom % 4) == 0) req = '0;
            ready = (($urandom % 100) < rdy_pct);
        end
    endtask

    initial begin
        // R1 reset state
        cyc(3);
        expect_gnt('0, "R1");
        rst = 1'b0;
        @(negedge clk);
        expect_gnt('0, "R1");

        // R10 park on last before any grant: nothing
        tag = "R10"; park_mode = 2'd1;
        cyc(3);
        expect_gnt('0, "R10");

        // R12 latency and R3 scan from master 0
        tag = "R12"; park_mode = 2'd0;
        req = 16'h0022;
        @(negedge clk);
        expect_gnt(16'h0002, "R12");
        req = 16'h0000;
        @(negedge clk);
        expect_gnt('0, "R9");
        tag = "R3"; req = 16'h0022;
        @(negedge clk);
        expect_gnt(16'h0020, "R3");

        // R10 park on last after a grant
        tag = "R10"; park_mode = 2'd1; req = '0;
        cyc(2);
        expect_gnt(16'h0020, "R10");

        // R4 fixed priority with a tie
        tag = "R4"; park_mode = 2'd0; arb_fixed = 1'b1;
        prio_vec = '0;
        prio_vec[5*4 +: 4] = 4'd9; prio_vec[7*4 +: 4] = 4'd9; prio_vec[2*4 +: 4] = 4'd3;
        req = 16'h00A4;
        @(negedge clk);
        expect_gnt(16'h0020, "R4");

        // R5 hold while beat pending
        tag = "R5"; req = 16'hFFFF; ready = 1'b0;
        cyc(6);
        expect_gnt(16'h0020, "R5");

        // R6 owner drops request
        tag = "R6"; req = 16'h0080;
        @(negedge clk);
        expect_gnt(16'h0080, "R6");

        // R11 fixed park
        tag = "R11"; req = '0; park_mode = 2'd2; park_id = 4'd11;
        cyc(2);
        expect_gnt(16'h0800, "R11");

        // R3 rotating random
        tag = "R3"; arb_fixed = 1'b0; park_mode = 2'd0;
        rand_run(400, 40, 50);
        // R4 priority random
        tag = "R4"; arb_fixed = 1'b1;
        prio_vec = {$urandom, $urandom};
        rand_run(400, 40, 50);
        // R7 burst caps
        tag = "R7"; arb_fixed = 1'b0; req = '1;
        blim_vec = N*3'({$urandom, $urandom});
        rand_run(500, 10, 70);
        arb_fixed = 1'b1;
        rand_run(300, 10, 70);
        // R8 hold limit
        tag = "R8"; blim_vec = '0; arb_fixed = 1'b0;
        for (int s = 0; s < 6; s++) begin
            slot_cycles = SW'(s);
            rand_run(120, 15, 40);
        end
        // R7 and R8 at the same edge
        tag = "R8"; blim_vec = {N{3'd2}}; slot_cycles = 8'd4; ready = 1'b1;
        req = 16'h0301;
        cyc(40);
        // parking modes
        slot_cycles = 8'd3; blim_vec = N*3'({$urandom, $urandom});
        tag = "R9";  park_mode = 2'd3; rand_run(200, 30, 60);
        tag = "R10"; park_mode = 2'd1; rand_run(200, 30, 60);
        tag = "R11"; park_mode = 2'd2; park_id = 4'd6; rand_run(200, 30, 60);
        // R1 mid-run reset
        tag = "R1"; rst = 1'b1;
        cyc(2);
        expect_gnt('0, "R1");
        rst = 1'b0;
        cyc(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule